// File: doc/BRIEF.md
# Partitioned Subword SIMD ALU

This block is a 64-bit arithmetic unit whose word can be split into independent lanes. The lanes are 8, 16, 32 or 64 bits wide. One operation applies to every lane at once. The unit can add or subtract lanes, and a sum may wrap or be clamped, with signed or unsigned limits. It can also compare lanes as signed values and return a mask per lane. Finally it can merge two operands bit by bit under a mask.

The compare and the merge together give partial predication. A compare builds a mask that is all ones where the first operand is greater. A later merge then takes each lane from one of two sources. Code can therefore pick per lane between two computed values without a data-dependent branch.

The adder is built from 8-bit slices. Where one lane ends and the next begins, the carry chain is cut. Each accepted operation shows up on the result register one clock later, together with a valid flag.

Top module: `subword_alu`

## Requirements
- R1: While reset is asserted (`rstN` low), `outValid` is 0 and `result` is all zeros.
- R2: `outValid` equals `inValid` one clock later. When `inValid` is high, `result` takes the outcome of that operation one clock later. When `inValid` is low, `result` holds its previous value.
- R3: `laneSize` sets the lane width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Lane k occupies bits [k*W +: W]. With `opSel`=00 (add) and wrap mode, each lane is (a+b) mod 2^W, and no carry passes into the next lane. For example, an all-ones lane plus 1 gives 0.
- R4: With `opSel`=01 (subtract) and wrap mode, each lane is (a-b) mod 2^W, and no borrow passes between lanes.
- R5: With `satMode`=01 (signed saturation), an add or subtract whose signed lane result overflows gives 2^(W-1)-1 when the true result is too large. It gives -2^(W-1) when the true result is too small.
- R6: With `satMode`=10 (unsigned saturation), an add that passes 2^W-1 gives all ones, and a subtract that goes below zero gives zero. `satMode` 00 and 11 both select wrap.
- R7: With `opSel`=10, each lane of the result is all ones if the lane of `srcA` is greater than the lane of `srcB` as a signed value, and all zeros otherwise. `satMode` has no effect on this operation.
- R8: With `opSel`=11, `result` = (`srcMask` & `srcA`) | (~`srcMask` & `srcB`), taken bit by bit. `laneSize` and `satMode` have no effect on this operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An operation is presented this cycle |
| opSel | input | 2 | 00 add, 01 subtract, 10 signed greater-than, 11 select |
| laneSize | input | 2 | Lane width code: 00=8, 01=16, 10=32, 11=64 |
| satMode | input | 2 | 00 wrap, 01 signed saturate, 10 unsigned saturate, 11 wrap |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| srcMask | input | 64 | Bit mask for select |
| outValid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
Every result and `outValid` are due exactly one rising edge after the operation is presented. The bench therefore drives each operation on a falling edge and samples 1 ns after the next rising edge. Operations follow each other back to back, so each sample shows only the operation that preceded it. The hold behaviour is checked on the edge after an idle cycle: the inputs are changed while `inValid` is low, and `result` must still show the last accepted value. Expected lane values come from a sign-extended arithmetic model in the bench. That model sweeps every op, lane size and saturation mode, including lane-boundary carry and borrow patterns.

// File: rtl/subword_alu_pkg.sv
`timescale 1ns/1ps
package subword_alu_pkg;
  localparam int DATA_W      = 64;
  localparam int SLICE_W     = 8;
  localparam int N_SLICE     = DATA_W / SLICE_W;
  localparam int SLICE_IDX_W = $clog2(N_SLICE);

  typedef enum logic [1:0] {
    OP_ADD    = 2'b00,
    OP_SUB    = 2'b01,
    OP_CMPGT  = 2'b10,
    OP_SELECT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SAT_WRAP     = 2'b00,
    SAT_SIGNED   = 2'b01,
    SAT_UNSIGNED = 2'b10,
    SAT_WRAP_ALT = 2'b11
  } sat_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                   load;
    logic                   subtract;
    logic                   swapOps;
    logic                   satSigned;
    logic                   satUnsigned;
    logic                   maskOut;
    logic                   selectOut;
    logic [N_SLICE-1:0]     laneFirst;
    logic [SLICE_IDX_W-1:0] laneSpan;
  } strobe_t;
endpackage

// File: rtl/subword_alu_ctrl.sv
`timescale 1ns/1ps
module subword_alu_ctrl
  import subword_alu_pkg::*;
(
  input  logic        inValid,
  input  logic [1:0]  opSel,
  input  logic [1:0]  laneSize,
  input  logic [1:0]  satMode,
  output strobe_t     strb
);
  op_e  opCode;
  sat_e satCode;
  logic [SLICE_IDX_W-1:0] span;
  logic [N_SLICE-1:0] firstVec;

  assign opCode  = op_e'(opSel);
  assign satCode = sat_e'(satMode);
  // slices per lane minus one: 0,1,3,7
  assign span = SLICE_IDX_W'((32'd1 << laneSize) - 32'd1);

  generate
    for (genvar i = 0; i < N_SLICE; i++) begin : g_first
      assign firstVec[i] = ((SLICE_IDX_W'(i) & span) == '0);
    end
  endgenerate

  always_comb begin
    strb = '0;
    strb.load      = inValid;
    strb.laneFirst = firstVec;
    strb.laneSpan  = span;
    unique case (opCode)
      OP_ADD, OP_SUB: begin
        strb.subtract    = (opCode == OP_SUB);
        strb.satSigned   = (satCode == SAT_SIGNED);
        strb.satUnsigned = (satCode == SAT_UNSIGNED);
      end
      OP_CMPGT: begin
        strb.subtract = 1'b1;
        strb.swapOps  = 1'b1;
        strb.maskOut  = 1'b1;
      end
      OP_SELECT: strb.selectOut = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/subword_alu_dp.sv
`timescale 1ns/1ps
module subword_alu_dp
  import subword_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcMask,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0]  opX, opY, opYInv, sumW, nextRes;
  logic [N_SLICE-1:0] carryOut, msbCarry, sgnOvf, ltFlag;

  assign opX    = strb.swapOps ? srcB : srcA;
  assign opY    = strb.swapOps ? srcA : srcB;
  assign opYInv = strb.subtract ? ~opY : opY;

  generate
    for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
      logic carryIn;
      if (i == 0) begin : g_lsb
        assign carryIn = strb.subtract;
      end else begin : g_mid
        // carry chain is cut where a new lane begins
        assign carryIn = strb.laneFirst[i] ? strb.subtract : carryOut[i-1];
      end
      assign {carryOut[i], sumW[i*SLICE_W +: SLICE_W]} =
        {1'b0, opX[i*SLICE_W +: SLICE_W]} + {1'b0, opYInv[i*SLICE_W +: SLICE_W]}
        + (SLICE_W+1)'(carryIn);
      assign msbCarry[i] = sumW[i*SLICE_W + SLICE_W-1] ^ opX[i*SLICE_W + SLICE_W-1]
                         ^ opYInv[i*SLICE_W + SLICE_W-1];
      assign sgnOvf[i]   = msbCarry[i] ^ carryOut[i];
      assign ltFlag[i]   = sumW[i*SLICE_W + SLICE_W-1] ^ sgnOvf[i];
    end
  endgenerate

  always_comb begin
    nextRes = '0;
    for (int i = 0; i < N_SLICE; i++) begin
      int unsigned top;
      logic satHit, negClamp;
      logic [SLICE_W-1:0] satByte, selByte;
      top      = i | int'(strb.laneSpan);
      negClamp = opX[top*SLICE_W + SLICE_W-1];
      satHit   = (strb.satSigned & sgnOvf[top])
               | (strb.satUnsigned & (strb.subtract ? ~carryOut[top] : carryOut[top]));
      if (strb.satSigned) begin
        if (top == i) satByte = negClamp ? {1'b1, {(SLICE_W-1){1'b0}}} : {1'b0, {(SLICE_W-1){1'b1}}};
        else          satByte = negClamp ? '0 : '1;
      end else begin
        satByte = strb.subtract ? '0 : '1;
      end
      selByte = (srcMask[i*SLICE_W +: SLICE_W] & srcA[i*SLICE_W +: SLICE_W])
              | (~srcMask[i*SLICE_W +: SLICE_W] & srcB[i*SLICE_W +: SLICE_W]);
      if (strb.selectOut)    nextRes[i*SLICE_W +: SLICE_W] = selByte;
      else if (strb.maskOut) nextRes[i*SLICE_W +: SLICE_W] = ltFlag[top] ? '1 : '0;
      else if (satHit)       nextRes[i*SLICE_W +: SLICE_W] = satByte;
      else                   nextRes[i*SLICE_W +: SLICE_W] = sumW[i*SLICE_W +: SLICE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strb.load;
      if (strb.load) result <= nextRes;
    end
  end

  // R2: nothing new loaded means the register holds
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(result));

  generate
    for (genvar i = 0; i < N_SLICE; i++) begin : g_mask_chk
      // R7: compare output bytes are always fully set or fully clear
      a_r7_mask_byte: assert property (@(posedge clk) disable iff (!rstN)
        (strb.load && strb.maskOut) |=>
          (result[i*SLICE_W +: SLICE_W] == '0 || result[i*SLICE_W +: SLICE_W] == '1));
    end
  endgenerate
endmodule

// File: rtl/subword_alu.sv
`timescale 1ns/1ps
module subword_alu
  import subword_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [1:0]        laneSize,
  input  logic [1:0]        satMode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcMask,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  strobe_t strb;

  subword_alu_ctrl ctrl_i (
    .inValid (inValid),
    .opSel   (opSel),
    .laneSize(laneSize),
    .satMode (satMode),
    .strb    (strb)
  );

  subword_alu_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .srcA    (srcA),
    .srcB    (srcB),
    .srcMask (srcMask),
    .outValid(outValid),
    .result  (result)
  );

  // R2: valid follows the input one cycle later
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_idle_follow: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R6: a clamped unsigned full-width add never drops below its first operand
  a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_ADD && satMode == SAT_UNSIGNED && laneSize == 2'b11)
      |=> result >= $past(srcA));

  // R5: two non-negative 64-bit values never saturate to a negative result
  a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_ADD && satMode == SAT_SIGNED && laneSize == 2'b11
      && !srcA[DATA_W-1] && !srcB[DATA_W-1]) |=> !result[DATA_W-1]);

  // R8: select merges bitwise under the mask
  a_r8_select_merge: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_SELECT) |=>
      result == (($past(srcMask) & $past(srcA)) | (~$past(srcMask) & $past(srcB))));
endmodule

// File: tb/subword_alu_tb_top.sv
`timescale 1ns/1ps
module subword_alu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = '0, laneSize = '0, satMode = '0;
  logic [63:0] srcA = '0, srcB = '0, srcMask = '0;
  logic        outValid;
  logic [63:0] result;
  int checks = 0;
  int errors = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  subword_alu dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .laneSize(laneSize), .satMode(satMode), .srcA(srcA), .srcB(srcB),
    .srcMask(srcMask), .outValid(outValid), .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // per-lane arithmetic model
  function automatic logic [63:0] model(input int op, input int size, input int sat,
                                        input logic [63:0] a, input logic [63:0] b,
                                        input logic [63:0] c);
    logic [63:0] r, shA, shB;
    logic signed [65:0] m, ua, ub, sa, sb, s, mx, mn, one;
    int w;
    if (op == 3) return (c & a) | (~c & b);
    w   = 8 << size;
    one = 66'sd1;
    m   = (one <<< w) - one;
    mx  = (one <<< (w-1)) - one;
    mn  = -(one <<< (w-1));
    r   = '0;
    for (int l = 0; l < 64 / w; l++) begin
      shA = a >> (l*w);
      shB = b >> (l*w);
      ua = {2'b00, shA} & m;
      ub = {2'b00, shB} & m;
      sa = ua[w-1] ? ua - (one <<< w) : ua;
      sb = ub[w-1] ? ub - (one <<< w) : ub;
      if (op == 2) begin
        s = (sa > sb) ? m : 66'sd0;
      end else if (sat == 1) begin
        s = (op == 0) ? sa + sb : sa - sb;
        if (s > mx) s = mx;
        if (s < mn) s = mn;
      end else if (sat == 2) begin
        s = (op == 0) ? ua + ub : ua - ub;
        if (s > m) s = m;
        if (s < 0) s = 66'sd0;
      end else begin
        s = (op == 0) ? ua + ub : ua - ub;
      end
      s = s & m;
      r = r | (s[63:0] << (l*w));
    end
    return r;
  endfunction

  function automatic string reqOf(input int op, input int sat);
    if (op == 3) return "R8";
    if (op == 2) return "R7";
    if (sat == 1) return "R5";
    if (sat == 2) return "R6";
    return (op == 0) ? "R3" : "R4";
  endfunction

  task automatic drive(input int op, input int size, input int sat,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                       input logic [63:0] exp, input string req);
    @(negedge clk);
    inValid  = 1'b1;
    opSel    = 2'(op);
    laneSize = 2'(size);
    satMode  = 2'(sat);
    srcA = a; srcB = b; srcMask = c;
    @(posedge clk);
    #1;
    chk(outValid == 1'b1, "R2", 64'(outValid), 64'd1);
    chk(result == exp, req, result, exp);
  endtask

  task automatic pattern(input int k, output logic [63:0] a, output logic [63:0] b);
    case (k)
      0: begin a = '1;                    b = 64'h0101010101010101; end
      1: begin a = 64'h7F7F7F7F7F7F7F7F;  b = 64'h0101010101010101; end
      2: begin a = 64'h8080808080808080;  b = 64'h0101010101010101; end
      3: begin a = 64'h00FF00FF00FF00FF;  b = 64'h0001000100010001; end
      4: begin a = 64'h0000FFFF0000FFFF;  b = 64'h0000000100000001; end
      5: begin a = 64'h00000000FFFFFFFF;  b = 64'h0000000000000001; end
      6: begin a = 64'h0000000000000000;  b = 64'h8000000000000000; end
      7: begin a = 64'h8000000080000000;  b = 64'h7FFFFFFF7FFFFFFF; end
      default: begin a = nextRand();      b = nextRand(); end
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] a, b, c, held;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", 64'(outValid), 64'd0);
    chk(result == '0, "R1", result, 64'd0);
    rstN = 1'b1;

    // directed corners with literal expectations
    drive(0, 0, 0, '1, 64'h0101010101010101, '0, 64'h0, "R3");
    drive(0, 1, 0, 64'h00FF00FF00FF00FF, 64'h0001000100010001, '0, 64'h0100010001000100, "R3");
    drive(0, 3, 0, '1, 64'h1, '0, 64'h0, "R3");
    drive(1, 0, 0, 64'h0, 64'h0101010101010101, '0, '1, "R4");
    drive(1, 2, 0, 64'h0000000100000000, 64'h0000000000000001, '0, 64'h00000001FFFFFFFF, "R4");
    drive(0, 0, 1, 64'h7F7F7F7F7F7F7F7F, 64'h0101010101010101, '0, 64'h7F7F7F7F7F7F7F7F, "R5");
    drive(1, 0, 1, 64'h8080808080808080, 64'h0101010101010101, '0, 64'h8080808080808080, "R5");
    drive(0, 1, 2, '1, 64'h0001000100010001, '0, '1, "R6");
    drive(1, 1, 2, 64'h0, 64'h0001000100010001, '0, 64'h0, "R6");
    drive(0, 1, 3, '1, 64'h0001000100010001, '0, 64'h0, "R6");
    drive(2, 2, 0, 64'h00000001FFFFFFFF, 64'h0, '0, 64'hFFFFFFFF00000000, "R7");
    drive(2, 2, 2, 64'h00000001FFFFFFFF, 64'h0, '0, 64'hFFFFFFFF00000000, "R7");
    drive(3, 0, 1, 64'hAAAAAAAAAAAAAAAA, 64'h5555555555555555, 64'hFF00FF00F0F0F0F0,
          64'hAA55AA55A5A5A5A5, "R8");

    // R2: idle cycle holds result and drops valid
    held = result;
    @(negedge clk);
    inValid = 1'b0;
    srcA = nextRand(); srcB = nextRand(); opSel = 2'b00;
    @(posedge clk);
    #1;
    chk(outValid == 1'b0, "R2", 64'(outValid), 64'd0);
    chk(result == held, "R2", result, held);

    // sweep of ops, lane sizes and modes
    for (int op = 0; op < 4; op++)
      for (int size = 0; size < 4; size++)
        for (int sat = 0; sat < 4; sat++)
          for (int k = 0; k < 32; k++) begin
            pattern(k, a, b);
            c = nextRand();
            drive(op, size, sat, a, b, c, model(op, size, sat, a, b, c), reqOf(op, sat));
          end

    @(negedge clk);
    inValid = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule